// File: doc/BRIEF.md
# Multi-Pattern Memory Address Generator

This block produces one address per access for a single 1024-word data memory. It runs beside the arithmetic datapath, so the datapath never spends a cycle on address arithmetic. One instance sits in front of each memory bank, so every bank can follow its own pattern in the same cycle. Four patterns can be selected: sequential, fixed stride, bit-reversed index (used to reorder FFT outputs) and circular buffer.

The settings are mode, base, stride, buffer length and the log2 of the transform size. A `start` pulse captures them and restarts the sequence at offset zero. Once `start` has been seen, `addr` holds the current address and `addr_valid` stays high. The consumer treats the address as a stream with the memory access as the accept signal. Raising `step` in a cycle means the current address has been used, and the next one appears after the following clock edge. While `step` is low the address holds, so the consumer can apply back-pressure for any number of cycles. Changes to the settings are ignored until the next `start`.

Top module: `agu_top`

## Requirements
- R1: After reset, `addr_valid` is 0 and `addr` is 0 until the first `start`.
- R2: A `start` pulse captures the settings. From the next cycle `addr_valid` is 1 and the first address is `cfg_base`. In bit-reversed mode the first address is `cfg_base` with its low L bits cleared.
- R3: Mode 0 (sequential): each step adds 1 to the address, wrapping modulo 1024.
- R4: Mode 1 (stride): each step adds `cfg_stride` to the address, modulo 1024.
- R5: Mode 2 (bit-reversed): L = `cfg_log2n` (1 to 10) and an index k counts steps from 0. The address keeps the upper 10-L bits of the base, and its low L bits are k mod 2^L with the bit order reversed.
- R6: Mode 3 (circular): the offset starts at 0 and becomes (offset + `cfg_stride`) mod `cfg_len` on each step, using one subtraction. The address is base + offset, modulo 1024. `cfg_len` is 1 to 1024 and `cfg_stride` must not exceed `cfg_len`.
- R7: A cycle without `step` leaves `addr` unchanged.
- R8: Changing any `cfg_*` input without a `start` has no effect on the address sequence.
- R9: When `start` and `step` are high in the same cycle, `start` wins: the sequence restarts at the new base and that step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture settings and restart the sequence |
| step | input | 1 | Current address consumed; advance by one |
| cfg_mode | input | 2 | 0 sequential, 1 stride, 2 bit-reversed, 3 circular |
| cfg_base | input | 10 | Base address |
| cfg_stride | input | 10 | Step size for stride and circular modes |
| cfg_len | input | 11 | Circular buffer length, 1 to 1024 |
| cfg_log2n | input | 4 | Bit-reversal field width, 1 to 10 |
| addr | output | 10 | Current address |
| addr_valid | output | 1 | Address is meaningful (a start has occurred) |

## Verification
The assertions check on every cycle:
- that `addr_valid` stays low until the first `start`;
- that the first address after `start` equals the captured base;
- the exact increment per step in sequential and stride modes;
- that the address holds while `step` is low;
- that a circular-mode address always lies within the buffer window.

The bench's scenarios are needed for the rest: the full bit-reversed ordering, the sequence of wrap points in circular mode, and wrap-around at the top of memory. They also show that setting changes made without a restart are ignored, and that a restart wins over a simultaneous step.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int AW = 10;
  localparam int LW = AW + 1;
  localparam int NW = 4;
  typedef enum logic [1:0] {
    M_LINEAR = 2'd0,
    M_STRIDE = 2'd1,
    M_BITREV = 2'd2,
    M_CIRC   = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_cfg_shadow.sv
module agu_cfg_shadow
  import agu_pkg::*;
#(
  parameter int W = AW,
  parameter int LEN_W = W + 1,
  parameter int N_W = NW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode_i,
  input  logic [W-1:0]     base_i,
  input  logic [W-1:0]     stride_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [N_W-1:0]   log2n_i,
  output agu_mode_e        mode_o,
  output logic [W-1:0]     base_o,
  output logic [W-1:0]     stride_o,
  output logic [LEN_W-1:0] len_o,
  output logic [N_W-1:0]   log2n_o
);
  logic [N_W-1:0] log2n_clamp;

  always_comb begin
    if (log2n_i == '0)                   log2n_clamp = N_W'(1);
    else if (32'(log2n_i) > W)           log2n_clamp = N_W'(W);
    else                                 log2n_clamp = log2n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o   <= M_LINEAR;
      base_o   <= '0;
      stride_o <= '0;
      len_o    <= LEN_W'(1);
      log2n_o  <= N_W'(1);
    end else if (start) begin
      mode_o   <= agu_mode_e'(mode_i);
      base_o   <= base_i;
      stride_o <= stride_i;
      len_o    <= (len_i == '0) ? LEN_W'(1) : len_i;
      log2n_o  <= log2n_clamp;
    end
  end
endmodule

// File: rtl/agu_offset_unit.sv
module agu_offset_unit
  import agu_pkg::*;
#(
  parameter int W = AW,
  parameter int LEN_W = W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  agu_mode_e        mode,
  input  logic [W-1:0]     stride,
  input  logic [LEN_W-1:0] len,
  output logic [W-1:0]     offset,
  output logic [W-1:0]     index,
  output logic             valid
);
  logic [W-1:0]     off_nxt;
  logic [LEN_W-1:0] circ_sum;
  logic             advance;

  assign advance  = valid && step && !start;
  assign circ_sum = LEN_W'(offset) + LEN_W'(stride);

  always_comb begin
    unique case (mode)
      M_LINEAR: off_nxt = offset + W'(1);
      M_STRIDE: off_nxt = offset + stride;
      M_CIRC:   off_nxt = (circ_sum >= len) ? W'(circ_sum - len) : W'(circ_sum);
      default:  off_nxt = offset;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
      index  <= '0;
      valid  <= 1'b0;
    end else if (start) begin
      offset <= '0;
      index  <= '0;
      valid  <= 1'b1;
    end else if (advance) begin
      offset <= off_nxt;
      index  <= index + W'(1);
    end
  end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev
  import agu_pkg::*;
#(
  parameter int W = AW,
  parameter int N_W = NW
) (
  input  logic [W-1:0]   index,
  input  logic [W-1:0]   base,
  input  logic [N_W-1:0] log2n,
  output logic [W-1:0]   addr
);
  logic [W-1:0] rev_full;
  logic [W-1:0] field;
  logic [W-1:0] mask;

  for (genvar b = 0; b < W; b++) begin : g_rev
    assign rev_full[b] = index[W-1-b];
  end

  assign field = rev_full >> (W - 32'(log2n));
  assign mask  = W'(((W+1)'(1)) << log2n) - W'(1);
  assign addr  = (base & ~mask) | (field & mask);
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int W = AW,
  parameter int LEN_W = W + 1,
  parameter int N_W = NW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [1:0]       cfg_mode,
  input  logic [W-1:0]     cfg_base,
  input  logic [W-1:0]     cfg_stride,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [N_W-1:0]   cfg_log2n,
  output logic [W-1:0]     addr,
  output logic             addr_valid
);
  agu_mode_e        mode_q;
  logic [W-1:0]     base_q, stride_q, offset, index, rev_addr;
  logic [LEN_W-1:0] len_q;
  logic [N_W-1:0]   log2n_q;

  agu_cfg_shadow #(.W(W), .LEN_W(LEN_W), .N_W(N_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mode_i(cfg_mode), .base_i(cfg_base), .stride_i(cfg_stride),
    .len_i(cfg_len), .log2n_i(cfg_log2n),
    .mode_o(mode_q), .base_o(base_q), .stride_o(stride_q),
    .len_o(len_q), .log2n_o(log2n_q)
  );

  agu_offset_unit #(.W(W), .LEN_W(LEN_W)) u_offset (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .mode(mode_q), .stride(stride_q), .len(len_q),
    .offset(offset), .index(index), .valid(addr_valid)
  );

  agu_bitrev #(.W(W), .N_W(N_W)) u_bitrev (
    .index(index), .base(base_q), .log2n(log2n_q), .addr(rev_addr)
  );

  assign addr = (mode_q == M_BITREV) ? rev_addr : base_q + offset;
endmodule

// File: rtl/agu_top_chk.sv
module agu_top_chk #(
  parameter int W = 10,
  parameter int LEN_W = W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             step,
  input logic [1:0]       cfg_mode,
  input logic [W-1:0]     cfg_base,
  input logic [W-1:0]     cfg_stride,
  input logic [LEN_W-1:0] cfg_len,
  input logic [W-1:0]     addr,
  input logic             addr_valid
);
  logic [1:0]       m_q;
  logic [W-1:0]     b_q, s_q;
  logic [LEN_W-1:0] l_q;
  logic             seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0; b_q <= '0; s_q <= '0; l_q <= LEN_W'(1); seen <= 1'b0;
    end else if (start) begin
      m_q <= cfg_mode; b_q <= cfg_base; s_q <= cfg_stride;
      l_q <= cfg_len; seen <= 1'b1;
    end
  end

  p_idle_until_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !addr_valid);

  p_first_is_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_mode != 2'd2) |=> (addr_valid && addr == $past(cfg_base)));

  p_linear_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && step && !start && m_q == 2'd0) |=> addr == W'($past(addr) + W'(1)));

  p_stride_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && step && !start && m_q == 2'd1) |=> addr == W'($past(addr) + $past(s_q)));

  p_circ_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && m_q == 2'd3 && s_q <= W'(l_q)) |-> LEN_W'(W'(addr - b_q)) < l_q);

  p_hold_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !step && !start) |=> $stable(addr));
endmodule

bind agu_top agu_top_chk #(.W(W), .LEN_W(LEN_W)) u_agu_top_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step(step),
  .cfg_mode(cfg_mode), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
  .cfg_len(cfg_len), .addr(addr), .addr_valid(addr_valid)
);

// File: tb/agu_top_bench.sv
module agu_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, step = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [9:0]  cfg_base = '0, cfg_stride = '0;
  logic [10:0] cfg_len = 11'd1;
  logic [3:0]  cfg_log2n = 4'd1;
  logic [9:0]  addr;
  logic        addr_valid;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  agu_top u_agu_top (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .cfg_mode(cfg_mode), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
    .cfg_len(cfg_len), .cfg_log2n(cfg_log2n), .addr(addr), .addr_valid(addr_valid)
  );

  task automatic check(string req, logic [9:0] exp_a, logic exp_v);
    n_chk++;
    if (addr !== exp_a || addr_valid !== exp_v) begin
      n_bad++;
      $display("FAIL %s: addr=%0d valid=%0b expected addr=%0d valid=%0b",
               req, addr, addr_valid, exp_a, exp_v);
    end
  endtask

  task automatic tick(logic st, logic sp);
    @(negedge clk);
    start = st; step = sp;
    @(posedge clk); #1;
    start = 1'b0; step = 1'b0;
  endtask

  task automatic configure(logic [1:0] m, logic [9:0] b, logic [9:0] s,
                           logic [10:0] l, logic [3:0] n);
    @(negedge clk);
    cfg_mode = m; cfg_base = b; cfg_stride = s; cfg_len = l; cfg_log2n = n;
  endtask

  function automatic logic [9:0] rev_bits(int k, int n);
    logic [9:0] r = '0;
    for (int i = 0; i < n; i++) r[n-1-i] = k[i];
    return r;
  endfunction

  task automatic t_reset();
    check("R1 reset", 10'd0, 1'b0);
  endtask

  task automatic t_linear();
    configure(2'd0, 10'd1020, 10'd0, 11'd1, 4'd1);
    tick(1, 0); check("R2 start linear", 10'd1020, 1'b1);
    for (int k = 1; k <= 6; k++) begin
      tick(0, 1); check("R3 linear wrap", 10'(1020 + k), 1'b1);
    end
  endtask

  task automatic t_stride();
    configure(2'd1, 10'd100, 10'd37, 11'd1, 4'd1);
    tick(1, 0); check("R2 start stride", 10'd100, 1'b1);
    for (int k = 1; k <= 30; k++) begin
      tick(0, 1); check("R4 stride", 10'(100 + 37 * k), 1'b1);
    end
  endtask

  task automatic t_bitrev(logic [9:0] b, int n, int steps);
    logic [9:0] upper;
    upper = b & ~10'((1 << n) - 1);
    configure(2'd2, b, 10'd0, 11'd1, 4'(n));
    tick(1, 0); check("R2 start bitrev", upper, 1'b1);
    for (int k = 1; k <= steps; k++) begin
      tick(0, 1);
      check("R5 bitrev", upper | rev_bits(k % (1 << n), n), 1'b1);
    end
  endtask

  task automatic t_circ(logic [9:0] b, int s, int l, int steps);
    configure(2'd3, b, 10'(s), 11'(l), 4'd1);
    tick(1, 0); check("R2 start circ", b, 1'b1);
    for (int k = 1; k <= steps; k++) begin
      tick(0, 1); check("R6 circular", 10'(b + ((k * s) % l)), 1'b1);
    end
  endtask

  task automatic t_hold();
    configure(2'd1, 10'd50, 10'd5, 11'd1, 4'd1);
    tick(1, 0); tick(0, 1); check("R4 pre-hold", 10'd55, 1'b1);
    for (int k = 0; k < 3; k++) begin
      tick(0, 0); check("R7 hold", 10'd55, 1'b1);
    end
  endtask

  task automatic t_cfg_ignored();
    configure(2'd0, 10'd300, 10'd0, 11'd1, 4'd1);
    tick(1, 0); tick(0, 1); check("R3 before change", 10'd301, 1'b1);
    configure(2'd1, 10'd700, 10'd9, 11'd4, 4'd3);
    tick(0, 0); check("R8 cfg ignored idle", 10'd301, 1'b1);
    tick(0, 1); check("R8 cfg ignored step", 10'd302, 1'b1);
    tick(1, 0); check("R2 new cfg after start", 10'd700, 1'b1);
    tick(0, 1); check("R4 new stride", 10'd709, 1'b1);
  endtask

  task automatic t_start_step();
    configure(2'd0, 10'd10, 10'd0, 11'd1, 4'd1);
    tick(1, 0); tick(0, 1); tick(0, 1); check("R3 pre", 10'd12, 1'b1);
    configure(2'd0, 10'd500, 10'd0, 11'd1, 4'd1);
    tick(1, 1); check("R9 start wins", 10'd500, 1'b1);
    tick(0, 1); check("R9 then step", 10'd501, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; t_reset();
    t_linear();
    t_stride();
    t_bitrev(10'h3A5, 3, 9);
    t_bitrev(10'h000, 10, 20);
    t_bitrev(10'h3FF, 1, 4);
    t_circ(10'd200, 3, 5, 12);
    t_circ(10'd1022, 1, 4, 9);
    t_circ(10'd40, 1, 1, 3);
    t_circ(10'd0, 7, 7, 3);
    t_circ(10'd600, 100, 1024, 15);
    t_hold();
    t_cfg_ignored();
    t_start_step();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule